// File: doc/BRIEF.md
# Eight-Lane Inverse DCT/ADST Transform Kernel

This block computes one 1-D eight-point inverse transform per beat. Each beat carries eight signed 16-bit coefficients and produces eight signed 16-bit samples. A per-beat mode bit chooses between two networks of exact integer rotations. One is the inverse discrete cosine transform butterfly. The other is the inverse asymmetric sine transform, whose odd-numbered outputs leave with their sign flipped. Every rotation multiplies by cosine constants scaled to 14 fractional bits. Each sum of products is then rounded back to a 16-bit value before the next stage uses it.

A 2-D inverse transform is built by running the kernel twice, over rows and then over columns. An outside controller handles the transpose between the passes, the choice of mode per pass, and the final down-scaling. The kernel is a three-stage pipeline with a valid/ready handshake at each end. Both modes take the same number of cycles, so beats of either mode may be mixed back to back.

Top module: `itx8_kernel`

## Requirements
- R1: While reset is active and right after it is released, `outValid` is 0. Once reset is released, `inReady` is 1.
- R2: Cosine mode (`inMode`=0), even half. Let C(k)=round(16384·cos(kπ/64)). The products (in0+in4)·C(16) and (in0−in4)·C(16) are formed, along with the rotation of (in2,in6) by C(24)/C(8). A four-point butterfly then combines them into even terms e0..e3. Lane k of each bus sits at bits [16k+15:16k].
- R3: Cosine mode, odd half. Inputs 1 and 7 are rotated by C(28)/C(4), and inputs 3 and 5 by C(12)/C(20). Sum and difference terms follow, and the middle pair is remultiplied by C(16) as a difference and as a sum. The final step gives out[i]=e[i]+d[7−i] and out[7−i]=e[i]−d[7−i] for i<4.
- R4: Sine mode (`inMode`=1). Three stages are applied:
  - stage 1 rotates the input pairs (7,0), (5,2), (3,4) and (1,6) by C(2)/C(30), C(10)/C(22), C(18)/C(14) and C(26)/C(6), then applies a 32-bit sum/difference;
  - stage 2 rotates by C(8)/C(24);
  - stage 3 scales by ±C(16).
  Output lanes 1, 3, 5 and 7 are negated.
- R5: Every rounded value is (s + 8192) shifted arithmetically right by 14, computed on the 32-bit sum s. A DC input of +100 in lane 0 in cosine mode gives 71 in all lanes, and −100 gives −71.
- R6: Intermediate and output values wrap modulo 2^16 and never saturate. In cosine mode, lanes 0 and 4 set to 32767 and −32768 give (−1, −19197, −19197, −1, −1, −19197, −19197, −1).
- R7: A beat accepted at a clock edge is presented on the output after the second following edge, when no stall occurs. This holds in both modes, and the mode may alternate on every beat.
- R8: While `outValid` is 1 and `outReady` is 0, the output beat is held unchanged. No beat is lost or duplicated under any stall pattern.
- R9: `inReady` is 1 exactly when the output slot is empty or is being consumed in the same cycle.
- R10: An all-zero input beat yields an all-zero output beat in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Kernel can take a beat this cycle |
| inMode | input | 1 | 0 = inverse cosine network, 1 = inverse sine network |
| inData | input | 128 | Eight signed 16-bit coefficients, lane k at [16k+15:16k] |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Consumer takes the output beat |
| outData | output | 128 | Eight signed 16-bit results, lane k at [16k+15:16k] |

## Verification
The bench targets five kinds of error. Hand-worked beats cover negative DC values, where a round-to-zero or truncating shift gives −70 instead of −71. They cover overflowing lane pairs, where a saturating adder returns 32767 instead of the wrapped −19197. Single-lane inputs in each half of the cosine network show a swapped constant or a reversed butterfly as lanes out of antisymmetry. A single-lane sine input exposes a missing sign flip on an odd lane. Random beats alternate the mode under heavy backpressure, which catches stage registers that drop the mode bit, beats that slip or repeat, and a ready that ignores the consumer.

// File: rtl/itx8_pkg.sv
package itx8_pkg;

  parameter int DW     = 16;
  parameter int NPT    = 8;
  parameter int CB     = 14;
  localparam int ACC_W = 2 * DW;
  localparam int BUS_W = DW * NPT;
  localparam int NSTG  = 3;
  localparam int ROUND_ADD = 1 << (CB - 1);

  // cosine of k*pi/64 scaled by 2^CB
  localparam int COS_K2  = 16305;
  localparam int COS_K4  = 16069;
  localparam int COS_K6  = 15679;
  localparam int COS_K8  = 15137;
  localparam int COS_K10 = 14449;
  localparam int COS_K12 = 13623;
  localparam int COS_K14 = 12665;
  localparam int COS_K16 = 11585;
  localparam int COS_K18 = 10394;
  localparam int COS_K20 = 9102;
  localparam int COS_K22 = 7723;
  localparam int COS_K24 = 6270;
  localparam int COS_K26 = 4756;
  localparam int COS_K28 = 3196;
  localparam int COS_K30 = 1606;

  typedef logic signed [DW-1:0]    lane_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef enum logic {TX_DCT = 1'b0, TX_ADST = 1'b1} tx_mode_e;

  typedef struct packed {
    logic [NSTG-1:0] load;
  } stage_strobe_t;

  function automatic acc_t mulC(input lane_t a, input int c);
    return acc_t'(a) * acc_t'(c);
  endfunction

  function automatic lane_t roundNarrow(input acc_t v);
    acc_t t;
    t = (v + ROUND_ADD) >>> CB;
    return t[DW-1:0];
  endfunction

endpackage

// File: rtl/itx8_ctrl.sv
module itx8_ctrl
  import itx8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output stage_strobe_t strobe
);

  logic [NSTG-1:0] vldQ;
  logic            advance;

  // whole pipe moves together unless the last slot is full and blocked
  assign advance  = rst_n && (!vldQ[NSTG-1] || outReady);
  assign inReady  = advance;
  assign outValid = vldQ[NSTG-1];

  always_comb begin
    strobe.load[0] = advance && inValid;
    for (int k = 1; k < NSTG; k++) begin
      strobe.load[k] = advance && vldQ[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vldQ <= '0;
    end else if (advance) begin
      vldQ <= {vldQ[NSTG-2:0], inValid};
    end
  end

endmodule

// File: rtl/itx8_dpath.sv
module itx8_dpath
  import itx8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  stage_strobe_t    strobe,
  input  logic             inMode,
  input  logic [BUS_W-1:0] inData,
  output logic [BUS_W-1:0] outData
);

  lane_t xin  [NPT];
  lane_t st1D [NPT];
  lane_t st1Q [NPT];
  lane_t st2D [NPT];
  lane_t st2Q [NPT];
  lane_t st3D [NPT];
  lane_t st3Q [NPT];
  logic  mode1Q, mode2Q;

  acc_t  pa [NPT];
  acc_t  qa [4];
  lane_t oDiff, oSum;
  lane_t zr [4];

  for (genvar k = 0; k < NPT; k++) begin : g_lane
    assign xin[k] = inData[k*DW +: DW];
    assign outData[k*DW +: DW] = st3Q[k];
  end

  // ---------------- stage 1: first rotation layer ----------------
  always_comb begin
    pa[0] = mulC(xin[7], COS_K2)  + mulC(xin[0], COS_K30);
    pa[1] = mulC(xin[7], COS_K30) - mulC(xin[0], COS_K2);
    pa[2] = mulC(xin[5], COS_K10) + mulC(xin[2], COS_K22);
    pa[3] = mulC(xin[5], COS_K22) - mulC(xin[2], COS_K10);
    pa[4] = mulC(xin[3], COS_K18) + mulC(xin[4], COS_K14);
    pa[5] = mulC(xin[3], COS_K14) - mulC(xin[4], COS_K18);
    pa[6] = mulC(xin[1], COS_K26) + mulC(xin[6], COS_K6);
    pa[7] = mulC(xin[1], COS_K6)  - mulC(xin[6], COS_K26);
    if (inMode == TX_ADST) begin
      for (int k = 0; k < 4; k++) begin
        st1D[k]   = roundNarrow(pa[k] + pa[k+4]);
        st1D[k+4] = roundNarrow(pa[k] - pa[k+4]);
      end
    end else begin
      st1D[0] = roundNarrow(mulC(xin[0], COS_K16) + mulC(xin[4], COS_K16));
      st1D[1] = roundNarrow(mulC(xin[0], COS_K16) - mulC(xin[4], COS_K16));
      st1D[2] = roundNarrow(mulC(xin[2], COS_K24) - mulC(xin[6], COS_K8));
      st1D[3] = roundNarrow(mulC(xin[2], COS_K8)  + mulC(xin[6], COS_K24));
      st1D[4] = roundNarrow(mulC(xin[1], COS_K28) - mulC(xin[7], COS_K4));
      st1D[5] = roundNarrow(mulC(xin[5], COS_K12) - mulC(xin[3], COS_K20));
      st1D[6] = roundNarrow(mulC(xin[5], COS_K20) + mulC(xin[3], COS_K12));
      st1D[7] = roundNarrow(mulC(xin[1], COS_K4)  + mulC(xin[7], COS_K28));
    end
  end

  // ---------------- stage 2: butterflies plus second rotation ----------------
  always_comb begin
    oDiff = st1Q[4] - st1Q[5];
    oSum  = st1Q[7] - st1Q[6];
    qa[0] = mulC(st1Q[4], COS_K8)  + mulC(st1Q[5], COS_K24);
    qa[1] = mulC(st1Q[4], COS_K24) - mulC(st1Q[5], COS_K8);
    qa[2] = mulC(st1Q[7], COS_K8)  - mulC(st1Q[6], COS_K24);
    qa[3] = mulC(st1Q[6], COS_K8)  + mulC(st1Q[7], COS_K24);
    if (mode1Q == TX_ADST) begin
      st2D[0] = st1Q[0] + st1Q[2];
      st2D[1] = st1Q[1] + st1Q[3];
      st2D[2] = st1Q[0] - st1Q[2];
      st2D[3] = st1Q[1] - st1Q[3];
      st2D[4] = roundNarrow(qa[0] + qa[2]);
      st2D[5] = roundNarrow(qa[1] + qa[3]);
      st2D[6] = roundNarrow(qa[0] - qa[2]);
      st2D[7] = roundNarrow(qa[1] - qa[3]);
    end else begin
      st2D[0] = st1Q[0] + st1Q[3];
      st2D[1] = st1Q[1] + st1Q[2];
      st2D[2] = st1Q[1] - st1Q[2];
      st2D[3] = st1Q[0] - st1Q[3];
      st2D[4] = st1Q[4] + st1Q[5];
      st2D[5] = roundNarrow(mulC(oSum, COS_K16) - mulC(oDiff, COS_K16));
      st2D[6] = roundNarrow(mulC(oDiff, COS_K16) + mulC(oSum, COS_K16));
      st2D[7] = st1Q[6] + st1Q[7];
    end
  end

  // ---------------- stage 3: output butterfly or final scaling ----------------
  always_comb begin
    zr[0] = roundNarrow(mulC(st2Q[2], COS_K16) + mulC(st2Q[3], COS_K16));
    zr[1] = roundNarrow(mulC(st2Q[2], COS_K16) - mulC(st2Q[3], COS_K16));
    zr[2] = roundNarrow(mulC(st2Q[6], COS_K16) + mulC(st2Q[7], COS_K16));
    zr[3] = roundNarrow(mulC(st2Q[6], COS_K16) - mulC(st2Q[7], COS_K16));
    if (mode2Q == TX_ADST) begin
      st3D[0] = st2Q[0];
      st3D[1] = -st2Q[4];
      st3D[2] = zr[2];
      st3D[3] = -zr[0];
      st3D[4] = zr[1];
      st3D[5] = -zr[3];
      st3D[6] = st2Q[5];
      st3D[7] = -st2Q[1];
    end else begin
      for (int i = 0; i < NPT/2; i++) begin
        st3D[i]         = st2Q[i] + st2Q[NPT-1-i];
        st3D[NPT-1-i]   = st2Q[i] - st2Q[NPT-1-i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPT; k++) begin
        st1Q[k] <= '0;
        st2Q[k] <= '0;
        st3Q[k] <= '0;
      end
      mode1Q <= 1'b0;
      mode2Q <= 1'b0;
    end else begin
      if (strobe.load[0]) begin
        st1Q   <= st1D;
        mode1Q <= inMode;
      end
      if (strobe.load[1]) begin
        st2Q   <= st2D;
        mode2Q <= mode1Q;
      end
      if (strobe.load[2]) begin
        st3Q <= st3D;
      end
    end
  end

endmodule

// File: rtl/itx8_kernel.sv
module itx8_kernel
  import itx8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inMode,
  input  logic [BUS_W-1:0] inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [BUS_W-1:0] outData
);

  stage_strobe_t strobe;

  itx8_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  itx8_dpath u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .inMode  (inMode),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/itx8_checker.sv
module itx8_checker
  import itx8_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             inReady,
  input logic [BUS_W-1:0] inData,
  input logic             outValid,
  input logic             outReady,
  input logic [BUS_W-1:0] outData
);

  // R7: accepted beat plus two free advances puts it on the output
  a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inValid && inReady, 3) && $past(inReady, 2) && $past(inReady, 1) |-> outValid);

  // R8: a blocked output beat stays put
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outData));

  // R9: blocked output stops intake, empty output allows it
  a_r9_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |-> !inReady);

  a_r9_empty_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> inReady);

  // R10: zero beat maps to zero beat
  a_r10_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inValid && inReady && (inData == '0), 3) && $past(inReady, 2) && $past(inReady, 1)
      |-> outData == '0);

endmodule

bind itx8_kernel itx8_checker u_itx8_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inReady  (inReady),
  .inData   (inData),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/test_itx8_kernel.sv
module test_itx8_kernel;
  import itx8_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 100000;
  localparam int LAT_TIME   = 2 * CLK_PERIOD + CLK_PERIOD / 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             inValid = 1'b0;
  logic             inMode = 1'b0;
  logic [BUS_W-1:0] inData = '0;
  logic             outReady = 1'b0;
  logic             inReady;
  logic             outValid;
  logic [BUS_W-1:0] outData;

  itx8_kernel i_itx8_kernel (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inReady  (inReady),
    .inMode   (inMode),
    .inData   (inData),
    .outValid (outValid),
    .outReady (outReady),
    .outData  (outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [BUS_W-1:0] exp;
    string            tag;
    time              acc;
    bit               timed;
  } item_t;

  typedef int ivec_t [8];

  item_t sb [$];
  int    nRun = 0;
  int    nFail = 0;
  bit    stallPhase = 1'b0;
  bit    finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- independent reference ----------------
  function automatic int cosK(input int k);
    real v;
    v = 16384.0 * $cos(real'(k) * 3.14159265358979 / 64.0);
    return $rtoi(v + 0.5);
  endfunction

  function automatic shortint rnd(input int v);
    int t;
    t = (v + 8192) >>> 14;
    return shortint'(t);
  endfunction

  function automatic int m(input shortint a, input int k);
    return int'(a) * cosK(k);
  endfunction

  function automatic logic [BUS_W-1:0] pk(input ivec_t v);
    logic [BUS_W-1:0] r;
    for (int k = 0; k < 8; k++) r[k*16 +: 16] = 16'(v[k]);
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] model(input bit adst, input logic [BUS_W-1:0] d);
    shortint x [8];
    shortint y [8];
    shortint ev [4];
    shortint od [8];
    shortint a [8];
    int      s [8];
    logic [BUS_W-1:0] r;
    for (int k = 0; k < 8; k++) x[k] = shortint'(d[k*16 +: 16]);
    if (!adst) begin
      a[0] = rnd(m(x[0],16) + m(x[4],16));
      a[1] = rnd(m(x[0],16) - m(x[4],16));
      a[2] = rnd(m(x[2],24) - m(x[6],8));
      a[3] = rnd(m(x[2],8)  + m(x[6],24));
      a[4] = rnd(m(x[1],28) - m(x[7],4));
      a[5] = rnd(m(x[5],12) - m(x[3],20));
      a[6] = rnd(m(x[5],20) + m(x[3],12));
      a[7] = rnd(m(x[1],4)  + m(x[7],28));
      ev[0] = shortint'(a[0] + a[3]);
      ev[1] = shortint'(a[1] + a[2]);
      ev[2] = shortint'(a[1] - a[2]);
      ev[3] = shortint'(a[0] - a[3]);
      od[4] = shortint'(a[4] + a[5]);
      od[7] = shortint'(a[6] + a[7]);
      y[0]  = shortint'(a[4] - a[5]);
      y[1]  = shortint'(a[7] - a[6]);
      od[5] = rnd(m(y[1],16) - m(y[0],16));
      od[6] = rnd(m(y[0],16) + m(y[1],16));
      for (int i = 0; i < 4; i++) begin
        y[i]   = shortint'(ev[i] + od[7-i]);
        y[7-i] = shortint'(ev[i] - od[7-i]);
      end
    end else begin
      s[0] = m(x[7],2)  + m(x[0],30);
      s[1] = m(x[7],30) - m(x[0],2);
      s[2] = m(x[5],10) + m(x[2],22);
      s[3] = m(x[5],22) - m(x[2],10);
      s[4] = m(x[3],18) + m(x[4],14);
      s[5] = m(x[3],14) - m(x[4],18);
      s[6] = m(x[1],26) + m(x[6],6);
      s[7] = m(x[1],6)  - m(x[6],26);
      for (int k = 0; k < 4; k++) begin
        a[k]   = rnd(s[k] + s[k+4]);
        a[k+4] = rnd(s[k] - s[k+4]);
      end
      s[4] = m(a[4],8)  + m(a[5],24);
      s[5] = m(a[4],24) - m(a[5],8);
      s[6] = m(a[7],8)  - m(a[6],24);
      s[7] = m(a[6],8)  + m(a[7],24);
      od[0] = shortint'(a[0] + a[2]);
      od[1] = shortint'(a[1] + a[3]);
      od[2] = shortint'(a[0] - a[2]);
      od[3] = shortint'(a[1] - a[3]);
      od[4] = rnd(s[4] + s[6]);
      od[5] = rnd(s[5] + s[7]);
      od[6] = rnd(s[4] - s[6]);
      od[7] = rnd(s[5] - s[7]);
      y[0] = od[0];
      y[1] = shortint'(-od[4]);
      y[2] = rnd(m(od[6],16) + m(od[7],16));
      y[3] = shortint'(-rnd(m(od[2],16) + m(od[3],16)));
      y[4] = rnd(m(od[2],16) - m(od[3],16));
      y[5] = shortint'(-rnd(m(od[6],16) - m(od[7],16)));
      y[6] = od[5];
      y[7] = shortint'(-od[1]);
    end
    for (int k = 0; k < 8; k++) r[k*16 +: 16] = y[k];
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] randVec();
    logic [BUS_W-1:0] r;
    for (int k = 0; k < 8; k++) begin
      if ($urandom_range(0, 3) == 0) r[k*16 +: 16] = 16'($urandom);
      else r[k*16 +: 16] = 16'(int'($urandom_range(0, 4000)) - 2000);
    end
    return r;
  endfunction

  // ---------------- driver ----------------
  task automatic send(input bit adst, input logic [BUS_W-1:0] d,
                      input logic [BUS_W-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    inValid = 1'b1;
    inMode  = adst;
    inData  = d;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    it.exp   = exp;
    it.tag   = tag;
    it.acc   = $time;
    it.timed = !stallPhase;
    sb.push_back(it);
  endtask

  task automatic sendModel(input bit adst, input logic [BUS_W-1:0] d, input string tag);
    send(adst, d, model(adst, d), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((sb.size() != 0) && (n < 2000)) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // ---------------- monitor / scoreboard ----------------
  initial begin
    logic [BUS_W-1:0] prevData;
    bit               prevStall;
    item_t            it;
    time              tNeg;
    prevStall = 1'b0;
    prevData  = '0;
    forever begin
      @(negedge clk);
      tNeg = $time;
      if (rst_n) begin
        if (prevStall) begin
          chk(outValid && (outData == prevData), "R8", "held beat changed",
              outData, prevData);
        end
        outReady = stallPhase ? ($urandom_range(0, 2) != 0) : 1'b1;
        #1;
        chk(inReady == (!outValid || outReady), "R9", "ready rule",
            BUS_W'(inReady), BUS_W'(!outValid || outReady));
        prevStall = outValid && !outReady;
        prevData  = outData;
        if (outValid && outReady) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R8", "unexpected output beat", outData, '0);
          end else begin
            it = sb.pop_front();
            chk(outData == it.exp, it.tag, "result", outData, it.exp);
            if (it.timed) begin
              chk((tNeg - it.acc) == LAT_TIME, "R7", "latency",
                  BUS_W'(tNeg - it.acc), BUS_W'(LAT_TIME));
            end
          end
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (TIMEOUT) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL R8 watchdog: actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid in reset", BUS_W'(outValid), '0);
    rst_n = 1'b1;
    #2;
    chk(outValid == 1'b0, "R1", "outValid after reset", BUS_W'(outValid), '0);
    chk(inReady == 1'b1, "R1", "inReady after reset", BUS_W'(inReady), BUS_W'(1));

    // hand-worked beats, no stalls
    send(1'b0, pk('{100, 0, 0, 0, 0, 0, 0, 0}),
         pk('{71, 71, 71, 71, 71, 71, 71, 71}), "R5");
    send(1'b0, pk('{-100, 0, 0, 0, 0, 0, 0, 0}),
         pk('{-71, -71, -71, -71, -71, -71, -71, -71}), "R5");
    send(1'b0, pk('{32767, 0, 0, 0, -32768, 0, 0, 0}),
         pk('{-1, -19197, -19197, -1, -1, -19197, -19197, -1}), "R6");
    send(1'b0, pk('{0, 0, 1000, 0, 0, 0, 0, 0}),
         pk('{924, 383, -383, -924, -924, -383, 383, 924}), "R2");
    send(1'b0, pk('{0, 1024, 0, 0, 0, 0, 0, 0}),
         pk('{1004, 851, 569, 200, -200, -569, -851, -1004}), "R3");
    send(1'b1, pk('{1024, 0, 0, 0, 0, 0, 0, 0}),
         pk('{100, 298, 482, 650, 791, 904, 980, 1019}), "R4");
    send(1'b0, '0, '0, "R10");
    send(1'b1, '0, '0, "R10");

    // back-to-back beats alternating mode
    for (int n = 0; n < 200; n++) begin
      if (n % 2 == 1) sendModel(1'b1, randVec(), "R4,R7");
      else            sendModel(1'b0, randVec(), "R2,R3,R7");
    end
    idle();
    drain();

    // random backpressure and random gaps
    stallPhase = 1'b1;
    for (int n = 0; n < 300; n++) begin
      sendModel(1'($urandom_range(0, 1)), randVec(), "R8");
      if ($urandom_range(0, 3) == 0) idle();
    end
    idle();
    drain();
    chk(sb.size() == 0, "R8", "beats left in scoreboard", BUS_W'(sb.size()), '0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule